// File: doc/BRIEF.md
# Prioritised Event Interrupt Latch

This block gathers numbered event pulses into a pending bitmap and drives a single fast-interrupt request line to a processor. Each cycle at most one event, selected by an index, can be raised. A readable current-event register tells the servicing software which pending source to handle next.

Software acknowledges by pulsing a clear-write strobe. Only every fourth strobe retires anything. On that strobe the lowest pending bit is dropped, and the current-event register advances to the next pending source above it. If nothing is left, the current-event register keeps its old value. That stale value still takes part in the priority comparison the next time an event is raised. The request line follows the bitmap. It rises as soon as one event is pending and falls when an acknowledgement empties the bitmap.

Top module: `evt_irq_latch`

## Requirements
- R1: After reset the pending bitmap, the current-event register and the acknowledge counter are zero, and the request line is low.
- R2: Raising event n (index n on `evt_id` with `evt_valid` high) sets pending bit n on the next clock edge.
- R3: The request line is high in every cycle after an edge that leaves at least one pending bit set, including the first event raised into an empty bitmap.
- R4: When event n is raised and no acting clear occurs in that cycle, the current-event register loads n if it reads 0 or holds a value greater than n.
- R5: A clear strobe that is the first, second or third since the last acting one changes neither the bitmap nor the current-event register.
- R6: The fourth clear strobe is the acting one. It removes the lowest-numbered set pending bit and nothing else, and it returns the counter to zero, even when the bitmap was empty.
- R7: After an acting clear, the current-event register holds the lowest set pending bit above the retired one. If no such bit exists, or the bitmap was empty, the register keeps its value.
- R8: The request line goes low on the edge at which an acting clear leaves the bitmap empty.
- R9: An event raised in the same cycle as an acting clear keeps its pending bit. The clear and the register advance act first, then the event's priority comparison is applied.
- R10: Raising event n while the current-event register holds a nonzero value below n leaves the register unchanged. This holds even if that value is no longer pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Raise the event named by evt_id this cycle |
| evt_id | input | IDX_W (3) | Index of the raised event |
| clr_wr | input | 1 | One software write to the clear register |
| irq_o | output | 1 | Fast-interrupt request line |
| cur_evt_o | output | IDX_W (3) | Current-event register |
| pending_o | output | NUM_EVT (8) | Pending bitmap |

## Verification
The hardest state to reach is a stale current-event register. It arises when the bitmap has been emptied while the register still names a high index, so a later, higher-numbered event is hidden behind a source that is no longer pending. The stimulus retires events one at a time with groups of four clear strobes until the bitmap is empty. It then raises a higher and a lower index and follows the register through the zero-value shortcut. It also aligns an event with the acting fourth strobe, and it runs a long stretch of random events and strobes compared cycle by cycle against a behavioural model.

// File: rtl/evl_pkg.sv
package evl_pkg;

    localparam int unsigned DEF_NUM_EVT    = 8;
    localparam int unsigned DEF_ACK_WRITES = 4;
    localparam int unsigned SCAN_MAX       = 32;

    // Result of a bit scan: whether a bit was found and where
    typedef struct packed {
        logic       hit;
        logic [4:0] idx;
    } scan_t;

    // Lowest set bit of v at position >= from, limited to n bits
    function automatic scan_t scan_up(logic [SCAN_MAX-1:0] v,
                                      int unsigned from,
                                      int unsigned n);
        scan_t r;
        r = '0;
        for (int i = SCAN_MAX - 1; i >= 0; i--) begin
            if (i < int'(n) && i >= int'(from) && v[i]) begin
                r.hit = 1'b1;
                r.idx = 5'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/evl_ack_div.sv
module evl_ack_div
    import evl_pkg::*;
#(
    parameter int unsigned ACK_WRITES = DEF_ACK_WRITES,
    localparam int unsigned CNT_W = (ACK_WRITES > 2) ? $clog2(ACK_WRITES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_wr,
    output logic             act,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ACK_WRITES - 1);

    assign act = clr_wr && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr_wr) begin
            cnt_q <= act ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/evl_pend.sv
module evl_pend
    import evl_pkg::*;
#(
    parameter int unsigned NUM_EVT = DEF_NUM_EVT,
    localparam int unsigned IDX_W = $clog2(NUM_EVT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               act,
    input  logic               evt_valid,
    input  logic [IDX_W-1:0]   evt_id,
    output logic [NUM_EVT-1:0] pend_q,
    output logic [NUM_EVT-1:0] pend_cleared,
    output scan_t              retired,
    output logic               irq_q
);
    logic [NUM_EVT-1:0] clr_mask;
    logic [NUM_EVT-1:0] set_mask;
    logic [NUM_EVT-1:0] pend_d;

    assign retired = scan_up(SCAN_MAX'(pend_q), 0, NUM_EVT);

    for (genvar b = 0; b < NUM_EVT; b++) begin : g_bit
        assign clr_mask[b]     = act && retired.hit && (retired.idx == 5'(b));
        assign set_mask[b]     = evt_valid && (evt_id == IDX_W'(b));
        assign pend_cleared[b] = pend_q[b] & ~clr_mask[b];
        assign pend_d[b]       = pend_cleared[b] | set_mask[b];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            irq_q  <= |pend_d;
        end
    end
endmodule

// File: rtl/evl_cur.sv
module evl_cur
    import evl_pkg::*;
#(
    parameter int unsigned NUM_EVT = DEF_NUM_EVT,
    localparam int unsigned IDX_W = $clog2(NUM_EVT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               act,
    input  scan_t              retired,
    input  logic [NUM_EVT-1:0] pend_cleared,
    input  logic               evt_valid,
    input  logic [IDX_W-1:0]   evt_id,
    output logic [IDX_W-1:0]   cur_q
);
    scan_t            nxt;
    logic [IDX_W-1:0] cur_mid;
    logic [IDX_W-1:0] cur_d;

    always_comb begin
        nxt = scan_up(SCAN_MAX'(pend_cleared), int'(retired.idx), NUM_EVT);
        // Advance after an acting clear, only when something remains above
        if (act && retired.hit && nxt.hit) begin
            cur_mid = IDX_W'(nxt.idx);
        end else begin
            cur_mid = cur_q;
        end
        // Event priority comparison against the post-clear value
        if (evt_valid && ((cur_mid == '0) || (evt_id < cur_mid))) begin
            cur_d = evt_id;
        end else begin
            cur_d = cur_mid;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end
endmodule

// File: rtl/evt_irq_latch.sv
module evt_irq_latch
    import evl_pkg::*;
#(
    parameter int unsigned NUM_EVT    = DEF_NUM_EVT,
    parameter int unsigned ACK_WRITES = DEF_ACK_WRITES,
    localparam int unsigned IDX_W = $clog2(NUM_EVT),
    localparam int unsigned CNT_W = (ACK_WRITES > 2) ? $clog2(ACK_WRITES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               evt_valid,
    input  logic [IDX_W-1:0]   evt_id,
    input  logic               clr_wr,
    output logic               irq_o,
    output logic [IDX_W-1:0]   cur_evt_o,
    output logic [NUM_EVT-1:0] pending_o
);
    logic               act;
    logic [CNT_W-1:0]   ack_cnt;
    logic [NUM_EVT-1:0] pend_cleared;
    scan_t              retired;

    evl_ack_div #(.ACK_WRITES(ACK_WRITES)) u_ack (
        .clk    (clk),
        .rst    (rst),
        .clr_wr (clr_wr),
        .act    (act),
        .cnt_q  (ack_cnt)
    );

    evl_pend #(.NUM_EVT(NUM_EVT)) u_pend (
        .clk          (clk),
        .rst          (rst),
        .act          (act),
        .evt_valid    (evt_valid),
        .evt_id       (evt_id),
        .pend_q       (pending_o),
        .pend_cleared (pend_cleared),
        .retired      (retired),
        .irq_q        (irq_o)
    );

    evl_cur #(.NUM_EVT(NUM_EVT)) u_cur (
        .clk          (clk),
        .rst          (rst),
        .act          (act),
        .retired      (retired),
        .pend_cleared (pend_cleared),
        .evt_valid    (evt_valid),
        .evt_id       (evt_id),
        .cur_q        (cur_evt_o)
    );
endmodule

// File: rtl/evt_irq_latch_chk.sv
module evt_irq_latch_chk #(
    parameter int unsigned NUM_EVT    = 8,
    parameter int unsigned ACK_WRITES = 4,
    localparam int unsigned IDX_W = $clog2(NUM_EVT),
    localparam int unsigned CNT_W = (ACK_WRITES > 2) ? $clog2(ACK_WRITES) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic               evt_valid,
    input logic [IDX_W-1:0]   evt_id,
    input logic               clr_wr,
    input logic               irq_o,
    input logic [IDX_W-1:0]   cur_evt_o,
    input logic [NUM_EVT-1:0] pending_o,
    input logic [CNT_W-1:0]   ack_cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ACK_WRITES - 1);
    logic acting;
    assign acting = clr_wr && (ack_cnt == LAST);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (pending_o == '0 && cur_evt_o == '0 && !irq_o && ack_cnt == '0));

    p_evt_sets_r2: assert property (@(posedge clk) disable iff (rst)
        evt_valid |=> pending_o[$past(evt_id)]);

    p_irq_follows_r3: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && pending_o == '0) |=> irq_o);

    p_cur_load_r4: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !acting && (cur_evt_o == '0 || evt_id < cur_evt_o))
        |=> cur_evt_o == $past(evt_id));

    p_early_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !acting && !evt_valid)
        |=> (pending_o == $past(pending_o) && $stable(cur_evt_o)));

    p_lowest_gone_r6: assert property (@(posedge clk) disable iff (rst)
        (acting && !evt_valid && pending_o != '0)
        |=> ((pending_o ^ $past(pending_o)) ==
             ($past(pending_o) & (~$past(pending_o) + 1'b1))));

    p_keep_cur_r7: assert property (@(posedge clk) disable iff (rst)
        (acting && !evt_valid && $countones(pending_o) <= 1)
        |=> $stable(cur_evt_o));

    p_irq_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (acting && !evt_valid && $countones(pending_o) == 1) |=> !irq_o);

    p_same_cycle_r9: assert property (@(posedge clk) disable iff (rst)
        (acting && evt_valid) |=> pending_o[$past(evt_id)]);

    p_stale_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !acting && cur_evt_o != '0 && evt_id > cur_evt_o)
        |=> $stable(cur_evt_o));
endmodule

bind evt_irq_latch evt_irq_latch_chk #(
    .NUM_EVT    (NUM_EVT),
    .ACK_WRITES (ACK_WRITES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_valid (evt_valid),
    .evt_id    (evt_id),
    .clr_wr    (clr_wr),
    .irq_o     (irq_o),
    .cur_evt_o (cur_evt_o),
    .pending_o (pending_o),
    .ack_cnt   (ack_cnt)
);

// File: tb/evt_irq_latch_tb.sv
module evt_irq_latch_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       evt_valid = 1'b0;
    logic [2:0] evt_id = '0;
    logic       clr_wr = 1'b0;
    logic       irq_o;
    logic [2:0] cur_evt_o;
    logic [7:0] pending_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Reference model state
    int m_pend = 0;
    int m_cur  = 0;
    int m_cnt  = 0;

    always #10 clk = ~clk;

    evt_irq_latch u_dut (
        .clk       (clk),
        .rst       (rst),
        .evt_valid (evt_valid),
        .evt_id    (evt_id),
        .clr_wr    (clr_wr),
        .irq_o     (irq_o),
        .cur_evt_o (cur_evt_o),
        .pending_o (pending_o)
    );

    task automatic check(string tag, string what, int act_v, int exp_v);
        total++;
        if (act_v != exp_v) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act_v, exp_v);
        end
    endtask

    task automatic compare(string tag);
        check(tag, "pending", int'(pending_o), m_pend);
        check(tag, "cur_evt", int'(cur_evt_o), m_cur);
        check(tag, "irq", int'(irq_o), (m_pend != 0) ? 1 : 0);
    endtask

    task automatic model_step(bit v, int id, bit c);
        bit act;
        act = c && (m_cnt == 3);
        if (c) m_cnt = act ? 0 : m_cnt + 1;
        if (act) begin
            int low;
            low = -1;
            for (int i = 0; i < 8; i++)
                if (low < 0 && m_pend[i]) low = i;
            if (low >= 0) begin
                m_pend[low] = 1'b0;
                for (int j = low; j < 8; j++)
                    if (m_pend[j]) begin m_cur = j; break; end
            end
        end
        if (v) begin
            if (m_cur == 0 || id < m_cur) m_cur = id;
            m_pend[id] = 1'b1;
        end
    endtask

    // Drive one cycle at the falling edge, model the rising edge, compare after it
    task automatic step(bit v, int id, bit c, string tag);
        @(negedge clk);
        evt_valid = v;
        evt_id    = 3'(id);
        clr_wr    = c;
        @(posedge clk);
        model_step(v, id, c);
        @(negedge clk);
        evt_valid = 1'b0;
        clr_wr    = 1'b0;
        compare(tag);
    endtask

    task automatic ack(string tag);
        for (int k = 0; k < 4; k++) step(1'b0, 0, 1'b1, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare("R1");
        // Three strobes straight after reset must not act if the counter started at 0
        step(1'b1, 6, 1'b0, "R2");
        for (int k = 0; k < 3; k++) step(1'b0, 0, 1'b1, "R1");
        step(1'b0, 0, 1'b1, "R6");
        check("R8", "irq after emptying", int'(irq_o), 0);
        // Fresh pattern: raise 5, 7, 2
        step(1'b1, 5, 1'b0, "R3");
        check("R3", "irq raised", int'(irq_o), 1);
        step(1'b1, 7, 1'b0, "R10");
        step(1'b1, 2, 1'b0, "R4");
        check("R4", "cur lower index", int'(cur_evt_o), 2);
        for (int k = 0; k < 3; k++) step(1'b0, 0, 1'b1, "R5");
        step(1'b0, 0, 1'b1, "R6");
        check("R7", "cur advances", int'(cur_evt_o), 5);
        ack("R7");
        check("R7", "cur advances again", int'(cur_evt_o), 7);
        ack("R8");
        check("R8", "irq low", int'(irq_o), 0);
        check("R7", "cur kept when empty", int'(cur_evt_o), 7);
        // Stale register
        step(1'b1, 3, 1'b0, "R4");
        step(1'b1, 0, 1'b0, "R4");
        step(1'b1, 4, 1'b0, "R4");
        step(1'b1, 6, 1'b0, "R10");
        check("R10", "stale hold", int'(cur_evt_o), 4);
        // Event together with the acting strobe
        for (int k = 0; k < 3; k++) step(1'b0, 0, 1'b1, "R5");
        step(1'b1, 1, 1'b1, "R9");
        check("R9", "bit survives", int'(pending_o[1]), 1);
        ack("R6");
        ack("R6");
        ack("R6");
        ack("R6");
        ack("R6");
        ack("R6");
        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom_range(0, 99);
            step(r < 30, $urandom_range(0, 7), r > 20 && r < 75, "R2");
        end
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule